// File: doc/BRIEF.md
# Cipher-Mode DMA Trigger Sequencer

This block paces an external DMA controller through multi-block data in a 128-bit block cipher. It has three trigger lines. Each line pulses once for every word the controller must move. After the cipher engine reports that a block is finished, the sequencer requests the result words one at a time on the read line. It then requests the next block's input words one at a time on the write line. Each request is single-cycle and is not repeated until the matching bus access has been acknowledged. This suits a DMA channel that runs in single-transfer mode.

Triggering runs only while the cipher-mode enable input is high. Electronic-codebook ordering is implemented in full: trigger line 0 carries the reads and trigger line 1 carries the writes. The chaining and feedback mode codes are accepted as selectable placeholders and produce no activity. Word mode moves 16-bit words, which gives eight transfers per phase. Byte mode gives sixteen transfers per phase. The sequence repeats once per block, so data longer than one block streams through unchanged.

Top module: `dts_trigger_seq`

## Requirements
- R1: While reset is asserted, and right after it, all three trigger outputs and `blk_done` are 0, and the sequencer is idle.
- R2: While `cm_en` is 0, no trigger output is ever 1, in the same cycle the enable falls as well as later, and `eng_done` and both acknowledges have no effect.
- R3: In mode code 00 (codebook), `eng_done` seen while waiting is followed one cycle later by the first pulse on trigger bit 0. After all read words, the write words follow on trigger bit 1. Trigger bit 2 never pulses.
- R4: Every trigger is a one-cycle pulse, and at most one trigger bit is 1 in any cycle.
- R5: After a trigger, no further trigger is issued until the matching acknowledge arrives: `rd_ack` in the read phase, `wr_ack` in the write phase. The next trigger appears in the cycle after the accepted acknowledge. An acknowledge of the other kind, or one that arrives while no trigger is outstanding, is ignored.
- R6: A phase holds BLOCK_BITS/WORD_BITS triggers (8 by default) when `byte_mode` is 0, and BLOCK_BITS/8 triggers (16) when it is 1.
- R7: `blk_done` is a one-cycle pulse in the cycle after the last write acknowledge of a block is accepted. The sequencer then waits for the next `eng_done`, so blocks repeat without limit.
- R8: When `cm_en` is cleared, the sequencer returns to idle at the next edge and clears its word count and any outstanding request. After it is re-enabled, it needs a fresh `eng_done` and starts again from word 0.
- R9: Mode codes 01, 10 and 11 are placeholders: with them the sequencer stays idle and produces no triggers and no `blk_done`. The mode is sampled only when the sequencer leaves idle, so changing it during a run has no effect.
- R10: `eng_done` is ignored in every state other than waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_en | input | 1 | Cipher-mode trigger enable |
| mode_sel | input | 2 | Chaining mode code (00 codebook; other codes placeholder) |
| byte_mode | input | 1 | 1: one trigger per byte; 0: one trigger per word |
| eng_done | input | 1 | Cipher engine finished the current block |
| rd_ack | input | 1 | DMA completed one output-word read |
| wr_ack | input | 1 | DMA completed one input-word write |
| trig | output | 3 | Per-transfer trigger pulses, one bit per line |
| blk_done | output | 1 | One-cycle pulse when a block's read and write phases are complete |

## Verification
The bench builds the block with its default parameters: a 128-bit block and 16-bit words. This makes both phase lengths, 8 and 16 transfers, short enough to sweep in full. It combines word and byte mode with acknowledge delays of zero to two cycles and with runs of one to three back-to-back blocks. During every wait it injects wrong-kind acknowledges and stray `eng_done` pulses. Every trigger position is checked at its exact cycle against counts computed from the block and word widths. Separate passes cover each placeholder mode code, a mode change in mid-run, and an enable drop in mid-phase followed by a full block from word 0.

// File: rtl/dts_pkg.sv
package dts_pkg;

  localparam int unsigned TRIG_LINES = 3;
  localparam int unsigned LSEL_W     = $clog2(TRIG_LINES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RDOUT = 2'd2,
    ST_WRIN  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    CM_ECB = 2'd0,
    CM_CBC = 2'd1,
    CM_OFB = 2'd2,
    CM_CFB = 2'd3
  } cmode_e;

  typedef struct packed {
    logic              ok;
    logic [LSEL_W-1:0] line;
  } line_sel_t;

  // Transfers per phase: one per byte in byte mode, else one per word.
  function automatic int unsigned words_per_phase(input int unsigned blk_bits,
                                                  input int unsigned word_bits,
                                                  input logic        byte_mode);
    return byte_mode ? (blk_bits / 8) : (blk_bits / word_bits);
  endfunction

  // Trigger line for a phase of a mode; ok=0 marks a placeholder mode.
  function automatic line_sel_t phase_line(input cmode_e m, input logic write_phase);
    line_sel_t s;
    s.ok   = 1'b0;
    s.line = '0;
    case (m)
      CM_ECB: begin
        s.ok   = 1'b1;
        s.line = write_phase ? LSEL_W'(1) : LSEL_W'(0);
      end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dts_word_ctr.sv
module dts_word_ctr #(
  parameter int CNT_W = 4,
  parameter int LIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LIM_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [LIM_W-1:0] cnt_ext;

  assign cnt_ext = LIM_W'(cnt);
  assign last    = (cnt_ext == (limit - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= last ? '0 : cnt + 1'b1;
  end

  // R6: the word index never reaches the phase length
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt_ext < limit));

  // R8: a clear leaves the count at zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/dts_trig_gate.sv
module dts_trig_gate #(
  parameter int LINES  = 3,
  parameter int LSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              arm,
  input  logic [LSEL_W-1:0] line_idx,
  input  logic              ack_ok,
  output logic [LINES-1:0]  trig,
  output logic              pending,
  output logic              accept
);

  logic pend_q;
  logic fire;

  assign fire    = en && arm && !pend_q;
  assign accept  = pend_q && ack_ok;
  assign pending = pend_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign trig[i] = fire && (line_idx == LSEL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (clr)     pend_q <= 1'b0;
    else if (fire)    pend_q <= 1'b1;
    else if (accept)  pend_q <= 1'b0;
  end

  // R4: never more than one line at a time
  a_r4_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig));

  // R4/R5: a trigger lasts one cycle, then waits for its acknowledge
  a_r5_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> (trig == '0));

  // R5: an outstanding request survives until acknowledged or cleared
  a_r5_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_ok && !clr) |=> pend_q);

endmodule

// File: rtl/dts_seq_fsm.sv
module dts_seq_fsm
  import dts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cm_en,
  input  cmode_e  mode,
  input  logic    eng_done,
  input  logic    accept,
  input  logic    last,
  output seq_st_e state,
  output cmode_e  run_mode,
  output logic    blk_done
);

  seq_st_e state_d;
  logic    block_end;

  assign block_end = (state == ST_WRIN) && accept && last;

  always_comb begin
    state_d = state;
    if (!cm_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (mode == CM_ECB)     state_d = ST_WAIT;
        ST_WAIT:  if (eng_done)           state_d = ST_RDOUT;
        ST_RDOUT: if (accept && last)     state_d = ST_WRIN;
        ST_WRIN:  if (accept && last)     state_d = ST_WAIT;
        default:                          state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      run_mode <= CM_ECB;
      blk_done <= 1'b0;
    end else begin
      state    <= state_d;
      blk_done <= cm_en && block_end;
      if (state == ST_IDLE && state_d != ST_IDLE) run_mode <= mode;
    end
  end

  // R8: dropping the enable forces idle
  a_r8_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_en |=> (state == ST_IDLE));

  // R9: placeholder codes never leave idle
  a_r9_placeholder_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && mode != CM_ECB) |=> (state == ST_IDLE));

  // R10: only eng_done moves the sequencer out of waiting
  a_r10_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && cm_en && !eng_done) |=> (state == ST_WAIT));

  // R7: completion is a single pulse and leaves the sequencer waiting
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);
  a_r7_done_waits: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (state == ST_WAIT));

endmodule

// File: rtl/dts_trigger_seq.sv
module dts_trigger_seq
  import dts_pkg::*;
#(
  parameter int BLOCK_BITS = 128,
  parameter int WORD_BITS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cm_en,
  input  logic [1:0] mode_sel,
  input  logic       byte_mode,
  input  logic       eng_done,
  input  logic       rd_ack,
  input  logic       wr_ack,
  output logic [2:0] trig,
  output logic       blk_done
);

  localparam int MAX_WORDS = BLOCK_BITS / 8;
  localparam int CNT_W     = $clog2(MAX_WORDS);
  localparam int LIM_W     = $clog2(MAX_WORDS + 1);

  seq_st_e          state;
  cmode_e           run_mode;
  line_sel_t        sel;
  logic [LIM_W-1:0] limit;
  logic [CNT_W-1:0] ctr_cnt;
  logic             ctr_last;
  logic             in_phase;
  logic             arm;
  logic             ack_ok;
  logic             accept;
  logic             pending;
  logic [TRIG_LINES-1:0] trig_bus;

  assign limit    = LIM_W'(words_per_phase(BLOCK_BITS, WORD_BITS, byte_mode));
  assign sel      = phase_line(run_mode, state == ST_WRIN);
  assign in_phase = (state == ST_RDOUT) || (state == ST_WRIN);
  assign arm      = in_phase && sel.ok;
  assign ack_ok   = ((state == ST_RDOUT) && rd_ack) || ((state == ST_WRIN) && wr_ack);
  assign trig     = trig_bus;

  dts_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cm_en    (cm_en),
    .mode     (cmode_e'(mode_sel)),
    .eng_done (eng_done),
    .accept   (accept),
    .last     (ctr_last),
    .state    (state),
    .run_mode (run_mode),
    .blk_done (blk_done)
  );

  dts_word_ctr #(
    .CNT_W (CNT_W),
    .LIM_W (LIM_W)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!cm_en),
    .inc   (accept),
    .limit (limit),
    .cnt   (ctr_cnt),
    .last  (ctr_last)
  );

  dts_trig_gate #(
    .LINES  (TRIG_LINES),
    .LSEL_W (LSEL_W)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cm_en),
    .clr      (!cm_en),
    .arm      (arm),
    .line_idx (sel.line),
    .ack_ok   (ack_ok),
    .trig     (trig_bus),
    .pending  (pending),
    .accept   (accept)
  );

  // R3: codebook runs never use the third line
  a_r3_line2_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == CM_ECB) |-> !trig[2]);

  // R6/R7: every block starts from word 0 while waiting
  a_r6_wait_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (ctr_cnt == '0));

  // R8: idle holds no outstanding request
  a_r8_idle_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !pending);

  // R2: no trigger is issued from idle or waiting
  a_r2_quiet_outside_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !in_phase |-> (trig == '0));

endmodule

// File: tb/sim_dts_trigger_seq.sv
module sim_dts_trigger_seq;

  localparam int BLK = 128;
  localparam int WB  = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cm_en;
  logic [1:0] mode_sel;
  logic       byte_mode;
  logic       eng_done;
  logic       rd_ack;
  logic       wr_ack;
  logic [2:0] trig;
  logic       blk_done;

  int nvec  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  dts_trigger_seq #(.BLOCK_BITS(BLK), .WORD_BITS(WB)) u0 (
    .clk(clk), .rst_n(rst_n), .cm_en(cm_en), .mode_sel(mode_sel),
    .byte_mode(byte_mode), .eng_done(eng_done), .rd_ack(rd_ack),
    .wr_ack(wr_ack), .trig(trig), .blk_done(blk_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_trig(input int exp, input string req);
    chk(int'(trig) == exp, req, int'(trig), exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Runs one block from the waiting state, ending in waiting again.
  task automatic run_block(input int nw, input int dly);
    rd_ack = 1'b1; wr_ack = 1'b1;
    tick();
    rd_ack = 1'b0; wr_ack = 1'b0;
    chk_trig(0, "R5 stray ack while waiting");
    eng_done = 1'b1;
    tick();
    eng_done = 1'b0;
    for (int ph = 0; ph < 2; ph++) begin
      for (int w = 0; w < nw; w++) begin
        chk_trig(ph == 0 ? 1 : 2, ph == 0 ? "R3 R6 read line pulse" : "R3 R6 write line pulse");
        chk(blk_done == 1'b0, "R7 done early", int'(blk_done), 0);
        tick();
        for (int k = 0; k < dly; k++) begin
          chk_trig(0, "R5 no retrigger before ack");
          if (ph == 0) wr_ack = 1'b1; else rd_ack = 1'b1;
          eng_done = 1'b1;
          tick();
          wr_ack = 1'b0; rd_ack = 1'b0; eng_done = 1'b0;
        end
        chk_trig(0, "R5 R10 wrong ack or eng_done ignored");
        if (ph == 0) rd_ack = 1'b1; else wr_ack = 1'b1;
        tick();
        rd_ack = 1'b0; wr_ack = 1'b0;
      end
    end
    chk(blk_done == 1'b1, "R7 done after last write ack", int'(blk_done), 1);
    chk_trig(0, "R7 quiet at block end");
    tick();
    chk(blk_done == 1'b0, "R7 done is one cycle", int'(blk_done), 0);
    chk_trig(0, "R7 waits for next eng_done");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cm_en = 1'b1; mode_sel = 2'b00; byte_mode = 1'b0;
    eng_done = 1'b1; rd_ack = 1'b0; wr_ack = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_trig(0, "R1 trig in reset");
      chk(blk_done == 1'b0, "R1 done in reset", int'(blk_done), 0);
    end
    cm_en = 1'b0; eng_done = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk_trig(0, "R1 trig after reset");

    // R2: disabled, all stimulus ignored
    for (int i = 0; i < 6; i++) begin
      eng_done = i[0]; rd_ack = 1'b1; wr_ack = i[1];
      tick();
      chk_trig(0, "R2 disabled no trigger");
      chk(blk_done == 1'b0, "R2 disabled no done", int'(blk_done), 0);
    end
    eng_done = 1'b0; rd_ack = 1'b0; wr_ack = 1'b0;

    // Sweep: word/byte mode x ack delay x back-to-back blocks
    for (int bm = 0; bm < 2; bm++) begin
      for (int dly = 0; dly < 3; dly++) begin
        for (int nb = 1; nb <= 3; nb++) begin
          byte_mode = bm[0]; mode_sel = 2'b00; cm_en = 1'b1;
          tick();
          for (int b = 0; b < nb; b++)
            run_block(bm != 0 ? BLK / 8 : BLK / WB, dly);
          cm_en = 1'b0;
          tick();
          chk_trig(0, "R2 after disable");
        end
      end
    end
    byte_mode = 1'b0;

    // R9: placeholder codes stay idle
    for (int m = 1; m < 4; m++) begin
      mode_sel = m[1:0]; cm_en = 1'b1;
      for (int c = 0; c < 6; c++) begin
        eng_done = c[0]; rd_ack = 1'b1; wr_ack = 1'b1;
        tick();
        chk_trig(0, "R9 placeholder no trigger");
        chk(blk_done == 1'b0, "R9 placeholder no done", int'(blk_done), 0);
      end
      eng_done = 1'b0; rd_ack = 1'b0; wr_ack = 1'b0; cm_en = 1'b0;
      tick();
    end

    // R9: mode change mid-run is ignored
    mode_sel = 2'b00; cm_en = 1'b1;
    tick();
    mode_sel = 2'b10;
    run_block(BLK / WB, 1);
    cm_en = 1'b0; mode_sel = 2'b00;
    tick();

    // R8: abort mid-phase, then restart from word 0
    cm_en = 1'b1;
    tick();
    eng_done = 1'b1;
    tick();
    eng_done = 1'b0;
    for (int w = 0; w < 3; w++) begin
      chk_trig(1, "R8 partial read phase");
      tick();
      rd_ack = 1'b1;
      tick();
      rd_ack = 1'b0;
    end
    cm_en = 1'b0;
    #1;
    chk_trig(0, "R2 R8 enable drop gates trigger at once");
    tick();
    chk_trig(0, "R8 idle after drop");
    cm_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      rd_ack = i[0];
      tick();
      chk_trig(0, "R8 needs fresh eng_done");
    end
    rd_ack = 1'b0;
    run_block(BLK / WB, 0);
    cm_en = 1'b0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule